// File: doc/BRIEF.md
# Phase Accumulator with Selectable Update Mode

The block produces the running phase word of one numerically controlled oscillator. A 48-bit frequency word is added to a 48-bit accumulator on every sample clock, and nothing gates or divides this step. The output phase is the upper 16 bits of the accumulator plus a 16-bit phase offset, summed modulo 2^16. Phase is measured in turns, so a full 16-bit wrap is one turn.

A mode bit sets how a phase-offset write behaves. In absolute mode the write also zeroes the accumulator, so the output lands exactly on the written value and advances from there. In relative mode only the offset changes, the accumulator keeps running, and the phase stays continuous apart from the step between the old and new offsets. Frequency, offset and mode each have their own write strobe. The block feeds a separate sine/cosine stage.

Top module: `phase_acc_gen`

## Requirements
- R1: After reset the accumulator, frequency and offset are zero, so `phase_o` is 0. The update mode is absolute (`mode_abs` = 1).
- R2: On every clock edge the accumulator adds the frequency word that was in effect before that edge. `phase_o` = acc[47:32] + offset mod 2^16, so a carry out of the lower 32 fractional bits shows up in `phase_o`.
- R3: A frequency write (`freq_we_i`) loads the new word at the edge. The accumulation step at that same edge still uses the old word, and the write never changes the accumulated value.
- R4: In absolute mode, a phase write (`phase_we_i`) zeroes the accumulator at the edge and loads the offset. In the cycle after, `phase_o` equals the written value. After that it advances by the frequency each cycle.
- R5: In relative mode, a phase write only replaces the offset while the accumulator takes its normal step. `phase_o` moves by (new − old offset) on top of its regular advance.
- R6: A mode write (`mode_we_i`, data `mode_abs_i`, 1 = absolute, 0 = relative) takes effect from the next edge. A phase write in the same cycle still follows the previous mode.
- R7: The accumulator and the output sum both wrap modulo their widths. A frequency word of 0xFFFF_0000_0000 steps the phase down by one each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| freq_we_i | input | 1 | Frequency write strobe |
| freq_i | input | 48 | Frequency word (turns per sample, 2^-48 units) |
| phase_we_i | input | 1 | Phase-offset write strobe |
| phase_i | input | 16 | Phase offset (turns, 2^-16 units) |
| mode_we_i | input | 1 | Update-mode write strobe |
| mode_abs_i | input | 1 | 1 = absolute, 0 = relative |
| phase_o | output | 16 | Output phase word |

## Verification
The output is a combinational sum of registered state, so a wrong accumulator, offset or mode bit reaches `phase_o` in the first cycle after the edge that corrupts it. A wrongly applied mode shows up as a phase that jumps to the written value when it should have kept its running value, or the reverse. The frequency words used put whole steps into the top 16 bits, plus one half step, so that a lost or doubled increment and a lost fractional carry each produce a distinct output value. A missing wrap produces one as well.

// File: rtl/phase_acc_pkg.sv
package phase_acc_pkg;
  typedef enum logic {
    MODE_REL = 1'b0,
    MODE_ABS = 1'b1
  } upd_mode_e;
endpackage

// File: rtl/pa_cfg_regs.sv
module pa_cfg_regs
  import phase_acc_pkg::*;
#(
  parameter int FREQ_W = 48,
  parameter int PH_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              freq_we_i,
  input  logic [FREQ_W-1:0] freq_i,
  input  logic              phase_we_i,
  input  logic [PH_W-1:0]   phase_i,
  input  logic              mode_we_i,
  input  logic              mode_abs_i,
  output logic [FREQ_W-1:0] freq_o,
  output logic [PH_W-1:0]   offset_o,
  output upd_mode_e         mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      freq_o   <= '0;
      offset_o <= '0;
      mode_o   <= MODE_ABS;
    end else begin
      if (freq_we_i)  freq_o   <= freq_i;
      if (phase_we_i) offset_o <= phase_i;
      if (mode_we_i)  mode_o   <= upd_mode_e'(mode_abs_i);
    end
  end

  assert_freq_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !freq_we_i |=> $stable(freq_o));
  assert_mode_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_we_i |=> $stable(mode_o));
  assert_offset_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_we_i |=> offset_o == $past(phase_i));
endmodule

// File: rtl/pa_accum.sv
module pa_accum #(
  parameter int FREQ_W = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic [FREQ_W-1:0] step_i,
  output logic [FREQ_W-1:0] acc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_o <= '0;
    else if (clear_i) acc_o <= '0;
    else              acc_o <= acc_o + step_i;
  end

  assert_clear_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> acc_o == '0);
  assert_advance_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> acc_o == FREQ_W'($past(acc_o) + $past(step_i)));
endmodule

// File: rtl/pa_phase_sum.sv
module pa_phase_sum #(
  parameter int FREQ_W = 48,
  parameter int PH_W   = 16
) (
  input  logic [FREQ_W-1:0] acc_i,
  input  logic [PH_W-1:0]   offset_i,
  output logic [PH_W-1:0]   phase_o
);
  localparam int FRAC_W = FREQ_W - PH_W;

  // integer part of the accumulator plus offset, modulo 2^PH_W
  always_comb phase_o = acc_i[FREQ_W-1:FRAC_W] + offset_i;

  always_comb
    assert_width_R7: assert (FRAC_W >= 0);
endmodule

// File: rtl/phase_acc_gen.sv
module phase_acc_gen
  import phase_acc_pkg::*;
#(
  parameter int FREQ_W = 48,
  parameter int PH_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              freq_we_i,
  input  logic [FREQ_W-1:0] freq_i,
  input  logic              phase_we_i,
  input  logic [PH_W-1:0]   phase_i,
  input  logic              mode_we_i,
  input  logic              mode_abs_i,
  output logic [PH_W-1:0]   phase_o
);
  logic [FREQ_W-1:0] freq_q;
  logic [FREQ_W-1:0] acc_q;
  logic [PH_W-1:0]   offset_q;
  upd_mode_e         mode_q;
  logic              clear_acc;

  pa_cfg_regs #(.FREQ_W(FREQ_W), .PH_W(PH_W)) u_cfg (
    .clk_i, .rst_ni, .freq_we_i, .freq_i, .phase_we_i, .phase_i,
    .mode_we_i, .mode_abs_i,
    .freq_o(freq_q), .offset_o(offset_q), .mode_o(mode_q)
  );

  // mode in force before this edge decides; a same-cycle mode write applies later
  assign clear_acc = phase_we_i && (mode_q == MODE_ABS);

  pa_accum #(.FREQ_W(FREQ_W)) u_acc (
    .clk_i, .rst_ni, .clear_i(clear_acc), .step_i(freq_q), .acc_o(acc_q)
  );

  pa_phase_sum #(.FREQ_W(FREQ_W), .PH_W(PH_W)) u_sum (
    .acc_i(acc_q), .offset_i(offset_q), .phase_o
  );

  assert_abs_exact_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_we_i && mode_q == MODE_ABS) |=> phase_o == $past(phase_i));
  assert_rel_continuous_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_we_i && mode_q == MODE_REL) |=> acc_q == FREQ_W'($past(acc_q) + $past(freq_q)));
  assert_freq_no_disturb_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freq_we_i && !phase_we_i) |=> acc_q == FREQ_W'($past(acc_q) + $past(freq_q)));
endmodule

// File: tb/phase_acc_gen_tb.sv
module phase_acc_gen_tb;
  typedef struct packed {
    logic        fwe;
    logic [47:0] freq;
    logic        pwe;
    logic [15:0] ph;
    logic        mwe;
    logic        mabs;
    logic [15:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam logic [47:0] F1  = 48'h0001_0000_0000;
  localparam logic [47:0] F16 = 48'h0010_0000_0000;
  localparam logic [47:0] FH  = 48'h0000_8000_0000;
  localparam vec_t VEC [NV] = '{
    '{1'b1, F1,    1'b0, 16'h0,    1'b0, 1'b0, 16'h0000, 8'd3}, // R3 old freq 0 used
    '{1'b0, 48'h0, 1'b0, 16'h0,    1'b0, 1'b0, 16'h0001, 8'd2}, // R2
    '{1'b0, 48'h0, 1'b0, 16'h0,    1'b0, 1'b0, 16'h0002, 8'd2},
    '{1'b0, 48'h0, 1'b1, 16'h1000, 1'b0, 1'b0, 16'h1000, 8'd4}, // R4 exact
    '{1'b0, 48'h0, 1'b0, 16'h0,    1'b0, 1'b0, 16'h1001, 8'd4},
    '{1'b0, 48'h0, 1'b0, 16'h0,    1'b1, 1'b0, 16'h1002, 8'd6}, // R6 go relative
    '{1'b0, 48'h0, 1'b1, 16'h2000, 1'b0, 1'b0, 16'h2003, 8'd5}, // R5 continuous
    '{1'b0, 48'h0, 1'b0, 16'h0,    1'b0, 1'b0, 16'h2004, 8'd5},
    '{1'b1, F16,   1'b0, 16'h0,    1'b0, 1'b0, 16'h2005, 8'd3}, // R3
    '{1'b0, 48'h0, 1'b0, 16'h0,    1'b0, 1'b0, 16'h2015, 8'd3},
    '{1'b0, 48'h0, 1'b1, 16'hFFF0, 1'b1, 1'b1, 16'h0015, 8'd6}, // R6 old mode + R7 wrap
    '{1'b0, 48'h0, 1'b1, 16'h0100, 1'b0, 1'b0, 16'h0100, 8'd6}, // R6 now absolute
    '{1'b0, 48'h0, 1'b0, 16'h0,    1'b0, 1'b0, 16'h0110, 8'd4},
    '{1'b1, FH,    1'b0, 16'h0,    1'b0, 1'b0, 16'h0120, 8'd3},
    '{1'b0, 48'h0, 1'b0, 16'h0,    1'b0, 1'b0, 16'h0120, 8'd2}, // R2 half step
    '{1'b0, 48'h0, 1'b0, 16'h0,    1'b0, 1'b0, 16'h0121, 8'd2}  // R2 carry
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        freq_we_i = 1'b0;
  logic [47:0] freq_i = '0;
  logic        phase_we_i = 1'b0;
  logic [15:0] phase_i = '0;
  logic        mode_we_i = 1'b0;
  logic        mode_abs_i = 1'b0;
  logic [15:0] phase_o;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2ns clk_i = ~clk_i;

  phase_acc_gen u_dut (.*);

  task automatic check(input logic [15:0] exp, input int req);
    n_chk++;
    if (phase_o !== exp) begin
      n_bad++;
      $display("FAIL R%0d: phase_o=%h expected=%h", req, phase_o, exp);
    end
  endtask

  task automatic step(input logic fwe, input logic [47:0] f, input logic pwe,
                      input logic [15:0] p, input logic mwe, input logic mabs);
    freq_we_i = fwe; freq_i = f; phase_we_i = pwe; phase_i = p;
    mode_we_i = mwe; mode_abs_i = mabs;
    @(posedge clk_i);
    @(negedge clk_i);
    freq_we_i = 1'b0; phase_we_i = 1'b0; mode_we_i = 1'b0;
  endtask

  initial begin
    #200us;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: done=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(16'h0000, 1); // R1 reset value
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(16'h0000, 1); // R1 stays zero with zero frequency

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].fwe, VEC[i].freq, VEC[i].pwe, VEC[i].ph, VEC[i].mwe, VEC[i].mabs);
      check(VEC[i].exp, int'(VEC[i].req));
    end

    // R1: mid-run reset restores zero state and absolute mode
    step(1'b0, 48'h0, 1'b0, 16'h0, 1'b1, 1'b0); // switch to relative first
    rst_ni = 1'b0;
    #1ns;
    check(16'h0000, 1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    step(1'b1, F1, 1'b0, 16'h0, 1'b0, 1'b0);
    check(16'h0000, 1);
    step(1'b0, 48'h0, 1'b0, 16'h0, 1'b0, 1'b0);
    step(1'b0, 48'h0, 1'b0, 16'h0, 1'b0, 1'b0);
    check(16'h0002, 2);
    step(1'b0, 48'h0, 1'b1, 16'h0042, 1'b0, 1'b0);
    check(16'h0042, 1); // R1 absolute after reset

    // R7: negative step wraps accumulator
    step(1'b1, 48'hFFFF_0000_0000, 1'b0, 16'h0, 1'b0, 1'b0);
    check(16'h0043, 7);
    step(1'b0, 48'h0, 1'b0, 16'h0, 1'b0, 1'b0);
    check(16'h0042, 7);
    step(1'b0, 48'h0, 1'b0, 16'h0, 1'b0, 1'b0);
    check(16'h0041, 7);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule